// File: doc/BRIEF.md
# Grouped level interrupt controller

This block collects up to 160 level-sensitive interrupt sources, arranged as five groups of 32 bit positions, and drives one CPU interrupt request line per group. Each group keeps a mask register in which a 1 blocks a source and a 0 lets it through. A group's line is raised whenever any of its implemented, pending and unmasked bits is set. A priority encoder reports the winning source as a group index, a bit index and a combined source number. The winner is the highest group with an active request, and within it the highest bit.

The lowest fourteen bit positions of the last group do not come from the general source inputs. They come from general-purpose pins, each with a programmable active level and a sticky status flag that software clears by writing 0. Software reaches the pending, mask, polarity and status words over a small word-addressed register bus. Reads return data one cycle after the read strobe.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: After reset every mask register equals its group's implemented-bit pattern, all pin status flags are 0, all polarity bits are 1, every interrupt line is low and `enc_valid` is 0.
- R2: Group g uses word addresses 4g to 4g+3. Pending sits at 4g+0 and is read-only. Mask sits at 4g+2, is read/write, and keeps only implemented bits. Words 20 and 21 hold pin polarity and pin status. Every other address reads 0. `bus_rdata` presents the addressed word on the cycle after `bus_rd` is sampled high.
- R3: The implemented bits are 0x0000EFFF for group 0, 0x00001FFF for group 1, 0x00000007 for group 2, 0x0003FFFF for group 3 and 0xFFFFFFFF for group 4. Unimplemented bits read 0 as pending and never raise a line or reach the encoder.
- R4: A bit requests service when it is pending and its mask bit is 0. `irq_line[g+2]` is high exactly when group g has such a bit. `irq_line[1:0]` stay low.
- R5: A group whose mask equals its full implemented-bit pattern keeps its line low.
- R6: With at least one request, `enc_valid` is 1. `enc_grp` is the highest group with a request, `enc_bit` is the highest requesting bit in that group, and `enc_src` equals enc_grp*32+enc_bit. With no request, `enc_valid` is 0.
- R7: A change on `src_in` or a pin reaches `irq_line` and the encoder outputs after exactly two rising clock edges.
- R8: Bits 0 to 13 of group 4 reflect the pin status flags and ignore `src_in[141:128]`. Polarity bit i (word 20) set to 1 makes pin i active-high; cleared to 0 makes it active-low.
- R9: A pin status flag (word 21, bit i) sets on the first edge its pin is at the active level and holds after the pin goes inactive. Writing 0 to it clears it, writing 1 has no effect, and a pin still active when the clear is written keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 160 | Level sources; bit g*32+b is group g, bit b |
| gpio_in | input | 14 | Pin inputs feeding group 4 bits 0 to 13 |
| bus_addr | input | 5 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| irq_line | output | 7 | CPU request lines; bit g+2 belongs to group g |
| enc_valid | output | 1 | A request is present |
| enc_grp | output | 3 | Winning group |
| enc_bit | output | 5 | Winning bit within the group |
| enc_src | output | 8 | Winning source number |

## Verification
The bench builds the block with its default parameters: five groups of 32 bits, fourteen pin-derived sources and a line offset of two. This makes the whole 160-bit source space small enough to walk one source at a time. That walk reaches every implemented bit, every unimplemented bit and every pin-overridden position. Pseudo-random source and mask patterns then exercise the cross-group and within-group priority against an arithmetic model. Directed pin sequences cover both polarities, stickiness, write-0 clearing and clear-while-active.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NGRP_D    = 5;
  localparam int unsigned GW_D      = 32;
  localparam int unsigned WIN_WORDS = 4;
  localparam int unsigned OFS_PEND  = 0;
  localparam int unsigned OFS_MASK  = 2;
  localparam int unsigned OFS_POL   = 0;
  localparam int unsigned OFS_STAT  = 1;
  // group 0 in the low word
  localparam logic [NGRP_D*GW_D-1:0] VALID_D =
    {32'hFFFF_FFFF, 32'h0003_FFFF, 32'h0000_0007, 32'h0000_1FFF, 32'h0000_EFFF};
endpackage

// File: rtl/irq_grp_unit.sv
module irq_grp_unit #(
  parameter int unsigned GW = 32,
  parameter logic [GW-1:0] VALID = '1,
  parameter logic [GW-1:0] OVR = '0,
  localparam int unsigned BIT_W = (GW > 1) ? $clog2(GW) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GW-1:0]    src_i,
  input  logic [GW-1:0]    ovr_i,
  input  logic             mask_we,
  input  logic [GW-1:0]    wdata_i,
  output logic [GW-1:0]    pend_o,
  output logic [GW-1:0]    mask_o,
  output logic             hit_o,
  output logic [BIT_W-1:0] top_o,
  output logic             irq_o
);
  logic [GW-1:0] raw_q, mask_q, eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= VALID;
      irq_o  <= 1'b0;
    end else begin
      raw_q <= src_i & VALID & ~OVR;
      if (mask_we) mask_q <= wdata_i & VALID;
      irq_o <= |eff;
    end
  end

  assign pend_o = raw_q | (ovr_i & OVR & VALID);
  assign mask_o = mask_q;
  assign eff    = pend_o & ~mask_q;
  assign hit_o  = |eff;

  // highest set bit wins: later iterations override earlier ones
  always_comb begin
    top_o = '0;
    for (int i = 0; i < int'(GW); i++)
      if (eff[i]) top_o = BIT_W'(i);
  end

  p_full_mask_low_r5: assert property (@(posedge clk) disable iff (rst)
    (mask_q == VALID) |=> !irq_o);
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irq_gpio_front.sv
module irq_gpio_front #(
  parameter int unsigned N = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] gpio_i,
  input  logic         pol_we,
  input  logic         stat_we,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] pol_o,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] pol_q, stat_q, act, keep;

  assign act  = ~(gpio_i ^ pol_q);
  assign keep = stat_we ? wdata_i : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '1;
      stat_q <= '0;
    end else begin
      if (pol_we) pol_q <= wdata_i;
      stat_q <= (stat_q & keep) | act;  // an active pin beats a clear
    end
  end

  assign pol_o  = pol_q;
  assign stat_o = stat_q;

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NGRP = 5,
  parameter int unsigned GW = 32,
  localparam int unsigned BIT_W = (GW > 1) ? $clog2(GW) : 1,
  localparam int unsigned GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int unsigned SRC_W = $clog2(NGRP * GW)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NGRP-1:0]       hit_i,
  input  logic [NGRP*BIT_W-1:0] top_i,
  output logic                  valid_o,
  output logic [GRP_W-1:0]      grp_o,
  output logic [BIT_W-1:0]      bit_o,
  output logic [SRC_W-1:0]      src_o
);
  logic             sel_v;
  logic [GRP_W-1:0] sel_g;
  logic [BIT_W-1:0] sel_b;

  always_comb begin
    sel_v = 1'b0;
    sel_g = '0;
    sel_b = '0;
    for (int g = 0; g < int'(NGRP); g++) begin
      if (hit_i[g]) begin
        sel_v = 1'b1;
        sel_g = GRP_W'(g);
        sel_b = top_i[g*BIT_W +: BIT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      grp_o   <= '0;
      bit_o   <= '0;
      src_o   <= '0;
    end else begin
      valid_o <= sel_v;
      grp_o   <= sel_g;
      bit_o   <= sel_b;
      src_o   <= SRC_W'(sel_g) * SRC_W'(GW) + SRC_W'(sel_b);
    end
  end
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NGRP = NGRP_D,
  parameter int unsigned GW = GW_D,
  parameter int unsigned NGPIO = 14,
  parameter int unsigned LINE_BASE = 2,
  parameter logic [NGRP*GW-1:0] VALID_MAP = VALID_D,
  localparam int unsigned BIT_W = (GW > 1) ? $clog2(GW) : 1,
  localparam int unsigned GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int unsigned SRC_W = $clog2(NGRP * GW),
  localparam int unsigned ADDR_W = $clog2((NGRP + 1) * WIN_WORDS),
  localparam int unsigned NLINE = NGRP + LINE_BASE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NGRP*GW-1:0] src_in,
  input  logic [NGPIO-1:0]   gpio_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [GW-1:0]      bus_wdata,
  output logic [GW-1:0]      bus_rdata,
  output logic [NLINE-1:0]   irq_line,
  output logic               enc_valid,
  output logic [GRP_W-1:0]   enc_grp,
  output logic [BIT_W-1:0]   enc_bit,
  output logic [SRC_W-1:0]   enc_src
);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(NGRP * WIN_WORDS + OFS_POL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NGRP * WIN_WORDS + OFS_STAT);

  logic [GW-1:0]         pend_a [NGRP];
  logic [GW-1:0]         mask_a [NGRP];
  logic [NGRP-1:0]       hit, irq_g, mask_we;
  logic [NGRP*BIT_W-1:0] tops;
  logic [NGPIO-1:0]      pol, stat;
  logic [GW-1:0]         stat_ext, rd_next;
  logic                  pol_we, stat_we;

  assign stat_ext = GW'(stat);

  // register decode
  always_comb begin
    mask_we = '0;
    for (int g = 0; g < int'(NGRP); g++)
      if (bus_wr && bus_addr == ADDR_W'(g * WIN_WORDS + OFS_MASK)) mask_we[g] = 1'b1;
  end
  assign pol_we  = bus_wr && (bus_addr == A_POL);
  assign stat_we = bus_wr && (bus_addr == A_STAT);

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < int'(NGRP); g++) begin
      if (bus_addr == ADDR_W'(g * WIN_WORDS + OFS_PEND)) rd_next = pend_a[g];
      if (bus_addr == ADDR_W'(g * WIN_WORDS + OFS_MASK)) rd_next = mask_a[g];
    end
    if (bus_addr == A_POL)  rd_next = GW'(pol);
    if (bus_addr == A_STAT) rd_next = stat_ext;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  for (genvar g = 0; g < int'(NGRP); g++) begin : g_grp
    localparam logic [GW-1:0] OV = (g == int'(NGRP) - 1) ? ({GW{1'b1}} >> (GW - NGPIO)) : '0;
    irq_grp_unit #(.GW(GW), .VALID(VALID_MAP[g*GW +: GW]), .OVR(OV)) u_grp (
      .clk(clk), .rst(rst),
      .src_i(src_in[g*GW +: GW]), .ovr_i(stat_ext),
      .mask_we(mask_we[g]), .wdata_i(bus_wdata),
      .pend_o(pend_a[g]), .mask_o(mask_a[g]),
      .hit_o(hit[g]), .top_o(tops[g*BIT_W +: BIT_W]), .irq_o(irq_g[g]));
  end

  irq_gpio_front #(.N(NGPIO)) u_gpio (
    .clk(clk), .rst(rst), .gpio_i(gpio_in),
    .pol_we(pol_we), .stat_we(stat_we), .wdata_i(bus_wdata[NGPIO-1:0]),
    .pol_o(pol), .stat_o(stat));

  irq_prio_enc #(.NGRP(NGRP), .GW(GW)) u_enc (
    .clk(clk), .rst(rst), .hit_i(hit), .top_i(tops),
    .valid_o(enc_valid), .grp_o(enc_grp), .bit_o(enc_bit), .src_o(enc_src));

  assign irq_line = {irq_g, {LINE_BASE{1'b0}}};

  p_enc_line_r6: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> irq_line[LINE_BASE + int'(enc_grp)]);
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !enc_valid |-> (irq_line == '0));
endmodule

// File: tb/sim_grouped_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grouped_irq_ctrl;
  logic         clk = 0;
  logic         rst = 1;
  logic [159:0] src_in = '0;
  logic [13:0]  gpio_in = '0;
  logic [4:0]   bus_addr = '0;
  logic         bus_wr = 0, bus_rd = 0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [6:0]   irq_line;
  logic         enc_valid;
  logic [2:0]   enc_grp;
  logic [4:0]   enc_bit;
  logic [7:0]   enc_src;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] vmask [5] = '{32'h0000_EFFF, 32'h0000_1FFF, 32'h0000_0007, 32'h0003_FFFF, 32'hFFFF_FFFF};
  logic [31:0] m_mask [5];
  logic [13:0] m_stat = '0;
  logic [31:0] lfsr = 32'h1234_5678;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  grouped_irq_ctrl u0 (.*);

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] pend_model(int g);
    logic [31:0] p = src_in[g*32 +: 32] & vmask[g];
    if (g == 4) p = (p & ~32'h3FFF) | {18'd0, m_stat};
    return p;
  endfunction

  task automatic expect_out(input string tag);
    logic [6:0] lines = '0;
    int eg = -1, eb = -1;
    for (int g = 0; g < 5; g++) begin
      logic [31:0] e = pend_model(g) & ~m_mask[g];
      if (e != 0) begin
        lines[g+2] = 1'b1; eg = g;
        for (int b = 0; b < 32; b++) if (e[b]) eb = b;
      end
    end
    chk(irq_line == lines, {tag, " R4 lines"}, irq_line, lines);
    chk(enc_valid == (eg >= 0), {tag, " R6 valid"}, enc_valid, eg >= 0);
    if (eg >= 0) begin
      chk(enc_grp == eg && enc_bit == eb, {tag, " R6 grp/bit"}, {enc_grp, enc_bit}, eg*32 + eb);
      chk(enc_src == eg*32 + eb, {tag, " R6 src"}, enc_src, eg*32 + eb);
    end
  endtask

  task automatic set_mask(int g, logic [31:0] m);
    bus_write(5'(g*4 + 2), m);
    m_mask[g] = m & vmask[g];
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 5; g++) m_mask[g] = vmask[g];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(irq_line == 0, "R1 lines after reset", irq_line, 0);
    chk(enc_valid == 0, "R1 enc_valid after reset", enc_valid, 0);
    for (int g = 0; g < 5; g++) begin
      bus_read(5'(g*4 + 2), rd);
      chk(rd == vmask[g], "R1 mask reset", rd, vmask[g]);
    end
    bus_read(5'd21, rd); chk(rd == 0, "R1 status reset", rd, 0);
    bus_read(5'd20, rd); chk(rd == 32'h3FFF, "R1 polarity reset", rd, 32'h3FFF);

    // R5/R3/R8: all sources high, masks full
    src_in = '1;
    settle();
    chk(irq_line == 0, "R5 full masks keep lines low", irq_line, 0);
    for (int g = 0; g < 5; g++) begin
      bus_read(5'(g*4), rd);
      chk(rd == pend_model(g), "R3 R8 pending implemented bits", rd, pend_model(g));
    end
    set_mask(2, 0);
    settle();
    expect_out("R5 one group open");
    chk(enc_src == 66, "R6 group2 top", enc_src, 66);

    // R2 register map details
    bus_write(5'd10, 32'hFFFF_FFFF);
    m_mask[2] = vmask[2];
    bus_read(5'd10, rd); chk(rd == 32'h7, "R2 mask keeps implemented bits", rd, 7);
    bus_write(5'd0, 32'hFFFF_FFFF);
    bus_read(5'd0, rd); chk(rd == pend_model(0), "R2 pending read-only", rd, pend_model(0));
    bus_read(5'd1, rd); chk(rd == 0, "R2 unmapped word 1", rd, 0);
    bus_read(5'd23, rd); chk(rd == 0, "R2 unmapped word 23", rd, 0);
    @(negedge clk); bus_addr = 5'd2; bus_rd = 1;
    @(negedge clk); bus_rd = 0; bus_addr = 5'd4;
    chk(bus_rdata == vmask[0], "R2 one-cycle read latency", bus_rdata, vmask[0]);
    @(negedge clk);
    chk(bus_rdata == vmask[0], "R2 rdata held without strobe", bus_rdata, vmask[0]);

    // R7 latency
    for (int g = 0; g < 5; g++) set_mask(g, 0);
    src_in = '0;
    settle();
    @(negedge clk); src_in[40] = 1'b1;
    @(negedge clk);
    chk(irq_line == 0, "R7 no change after one edge", irq_line, 0);
    @(negedge clk);
    chk(irq_line == 7'b0001000 && enc_src == 40, "R7 change after two edges", {irq_line, enc_src}, {7'b0001000, 8'd40});

    // R3 R6 R8 single-source sweep
    for (int s = 0; s < 160; s++) begin
      src_in = '0; src_in[s] = 1'b1;
      settle();
      if (s >= 128 && s < 142) expect_out("R8 sweep pin slot ignored");
      else if (vmask[s/32][s%32]) expect_out("R6 sweep implemented");
      else expect_out("R3 sweep unimplemented");
      bus_read(5'(s/32*4), rd);
      chk(rd == pend_model(s/32), "R3 sweep pending", rd, pend_model(s/32));
    end

    // R4 R6 random patterns
    for (int it = 0; it < 300; it++) begin
      for (int g = 0; g < 5; g++) begin
        logic [31:0] r = rnd();
        if (it % 3 == 0) r = r & rnd() & rnd();
        src_in[g*32 +: 32] = r;
        set_mask(g, rnd() | ((it % 2 == 0) ? rnd() : 32'h0));
      end
      settle();
      expect_out("R4 random");
      bus_read(5'(it % 5 * 4 + 2), rd);
      chk(rd == m_mask[it % 5], "R2 random mask readback", rd, m_mask[it % 5]);
    end

    // pin-derived sources
    src_in = '0;
    for (int g = 0; g < 4; g++) set_mask(g, 32'hFFFF_FFFF);
    set_mask(4, 0);
    bus_write(5'd21, 0); m_stat = '0;
    settle();
    expect_out("R9 idle");
    @(negedge clk); gpio_in[5] = 1'b1;
    @(negedge clk);
    chk(enc_valid == 0, "R7 pin after one edge", enc_valid, 0);
    @(negedge clk);
    chk(enc_valid && enc_src == 133, "R7 R8 pin after two edges", enc_src, 133);
    m_stat[5] = 1'b1;
    settle();
    expect_out("R8 pin active high");
    bus_read(5'd21, rd); chk(rd == 32'h20, "R9 status set", rd, 32'h20);
    bus_read(5'd16, rd); chk(rd == 32'h20, "R8 pending follows status", rd, 32'h20);
    gpio_in[5] = 1'b0;
    settle();
    expect_out("R9 sticky after pin drops");
    bus_write(5'd21, 32'hFFFF_FFFF);
    bus_read(5'd21, rd); chk(rd == 32'h20, "R9 write one no effect", rd, 32'h20);
    bus_write(5'd21, ~32'h20); m_stat = '0;
    settle();
    expect_out("R9 cleared by zero");
    gpio_in[3] = 1'b1; m_stat[3] = 1'b1;
    settle();
    bus_write(5'd21, 0);
    bus_read(5'd21, rd); chk(rd == 32'h8, "R9 active pin beats clear", rd, 32'h8);
    bus_write(5'd20, 32'h3FFF & ~32'h80); m_stat[7] = 1'b1;
    bus_read(5'd20, rd); chk(rd == (32'h3FFF & ~32'h80), "R8 polarity readback", rd, 32'h3FFF & ~32'h80);
    settle();
    expect_out("R8 active-low pin");
    chk(enc_src == 135, "R8 active-low source number", enc_src, 135);
    gpio_in[7] = 1'b1; gpio_in[3] = 1'b0;
    bus_write(5'd21, 0); m_stat = '0;
    src_in[130] = 1'b1;
    settle();
    expect_out("R8 src ignored in pin slot");
    chk(enc_valid == 0, "R8 idle with inactive pins", enc_valid, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule